// File: doc/BRIEF.md
# External Bus Hold Controller

This block lets an outside bus master take over a parallel external memory bus. It watches an active-low hold request. Before it acts on the request, it brings the request into the fast timing-clock domain. When it sees the request, it stops the local access engine from starting new cycles and lets any access already in flight finish. It then releases the address, data and control pads to high impedance, and one bus-clock period later it drives an active-low acknowledge. When the request returns high, the order is reversed: the acknowledge is withdrawn first, and one bus-clock period after that the pads are driven again and normal accesses may resume.

All pad-enable and acknowledge transitions are aligned to the rising edge of the half-rate bus clock-out. This edge is given to the block as a one-cycle enable pulse on the timing clock. The pad enables are replicated per pin, so the pad ring can use them directly.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with the request high: the acknowledge is high, every pad drive enable is high, and the engine grant is high. Asserting reset restores this state at once, even in the middle of a hold.
- R2: The request passes through two timing-clock flops. A fall applied before clock edge k first removes the grant after edge k+1, and not earlier.
- R3: The grant is high only when the controller is idle and the synchronized request is high. It stays low from the moment the low request is seen until the pads are driven again.
- R4: While the engine reports busy, the pad drive enables stay high. The pads float at the first bus-clock edge on which busy is low.
- R5: The address, data and control drive enables (read/write strobe plus zone selects) all fall together, on a bus-clock edge.
- R6: The acknowledge falls exactly one bus-clock period (two timing clocks) after the pads float. It is never low while any drive enable is high.
- R7: After the synchronized request returns high, the acknowledge rises on the next bus-clock edge. The drive enables rise one bus-clock period later. With the engine idle, the pads float within 4 timing clocks of the request falling, and are driven within 6 timing clocks of it rising.
- R8: If the request is withdrawn before the acknowledge has fallen, the controller still completes the grant (acknowledge low for one bus-clock period) and then runs the normal release sequence.
- R9: The acknowledge and the drive enables change only on a timing-clock edge where the bus-clock enable is high.
- R10: A request that falls while the controller is releasing the bus is not acted on until the drive enables are high again. After that it follows the normal entry sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_en | input | 1 | One-cycle pulse marking a rising edge of the half-rate bus clock-out |
| hold_req_n | input | 1 | Active-low bus hold request from the external master |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| eng_busy | input | 1 | Access engine has a cycle in progress |
| eng_grant | output | 1 | Access engine may start a new cycle |
| addr_drive | output | ADDR_W | Per-pin drive enable for the address pads |
| data_drive | output | DATA_W | Per-pin drive enable for the data pads |
| ctl_drive | output | CS_W+1 | Drive enables for the read/write strobe (bit 0) and zone selects |

## Verification
The hardest case to reach from the ports is a request that changes level while a sequence is already under way. This covers a withdrawal that arrives after the pads have floated but before the acknowledge, and a new fall that lands during the release period. Both cases depend on where the request edge falls relative to the two synchronizer stages and the bus-clock phase. The stimulus therefore drives the request, busy and bus-clock enable one timing clock at a time from a table, so that each edge lands on a chosen cycle. A drained access is stretched across several bus-clock edges, and busy is dropped on a cycle without a bus-clock pulse.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_FLOAT   = 3'd2,
    ST_HELD    = 3'd3,
    ST_RELEASE = 3'd4
  } bhc_state_e;

  function automatic logic pads_driven(input bhc_state_e st);
    return (st == ST_IDLE) || (st == ST_DRAIN);
  endfunction

endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= d;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
  import bhc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_en,
  input  logic       req_low,
  input  logic       eng_busy,
  output bhc_state_e state_q,
  output bhc_state_e state_d
);

  always_comb begin
    state_d = state_q;
    if (bclk_en) begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_low) state_d = eng_busy ? ST_DRAIN : ST_FLOAT;
        end
        ST_DRAIN: begin
          if (!eng_busy) state_d = ST_FLOAT;
        end
        ST_FLOAT:   state_d = ST_HELD;
        ST_HELD: begin
          if (!req_low) state_d = ST_RELEASE;
        end
        ST_RELEASE: state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/bhc_pad_ctl.sv
module bhc_pad_ctl
  import bhc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_en,
  input  bhc_state_e        state_d,
  output logic [ADDR_W-1:0] addr_drive,
  output logic [DATA_W-1:0] data_drive,
  output logic [CTL_W-1:0]  ctl_drive,
  output logic              ack_n
);

  logic drive_q, drive_d;
  logic ack_q, ack_d;

  always_comb begin
    drive_d = drive_q;
    ack_d   = ack_q;
    if (bclk_en) begin
      drive_d = pads_driven(state_d);
      ack_d   = (state_d != ST_HELD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b1;
      ack_q   <= 1'b1;
    end else begin
      drive_q <= drive_d;
      ack_q   <= ack_d;
    end
  end

  genvar a;
  generate
    for (a = 0; a < ADDR_W; a++) begin : g_addr
      assign addr_drive[a] = drive_q;
    end
    for (a = 0; a < DATA_W; a++) begin : g_data
      assign data_drive[a] = drive_q;
    end
    for (a = 0; a < CTL_W; a++) begin : g_ctl
      assign ctl_drive[a] = drive_q;
    end
  endgenerate

  assign ack_n = ack_q;

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bhc_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 32,
  parameter int CS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_en,
  input  logic              hold_req_n,
  output logic              hold_ack_n,
  input  logic              eng_busy,
  output logic              eng_grant,
  output logic [ADDR_W-1:0] addr_drive,
  output logic [DATA_W-1:0] data_drive,
  output logic [CS_W:0]     ctl_drive
);

  localparam int CTL_W = CS_W + 1;

  logic [1:0]  rst_pipe_q;
  logic        rst_int_n;
  logic        req_sync;
  logic        req_low;
  bhc_state_e  state_q;
  bhc_state_e  state_d;

  // reset: asserted at once, released after two clean clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  bhc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (hold_req_n),
    .q     (req_sync)
  );
  assign req_low = ~req_sync;

  bhc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bclk_en  (bclk_en),
    .req_low  (req_low),
    .eng_busy (eng_busy),
    .state_q  (state_q),
    .state_d  (state_d)
  );

  bhc_pad_ctl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTL_W  (CTL_W)
  ) u_pad (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bclk_en    (bclk_en),
    .state_d    (state_d),
    .addr_drive (addr_drive),
    .data_drive (data_drive),
    .ctl_drive  (ctl_drive),
    .ack_n      (hold_ack_n)
  );

  assign eng_grant = (state_q == ST_IDLE) && !req_low;

endmodule

// File: rtl/bus_hold_ctrl_chk.sv
module bus_hold_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int CS_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bclk_en,
  input logic              hold_req_n,
  input logic              hold_ack_n,
  input logic              eng_busy,
  input logic              eng_grant,
  input logic [ADDR_W-1:0] addr_drive,
  input logic [DATA_W-1:0] data_drive,
  input logic [CS_W:0]     ctl_drive
);

  // R6: acknowledge low only with every pad released
  p_ack_floated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (addr_drive == '0 && data_drive == '0 && ctl_drive == '0));

  // R6: the pads were already floating the cycle before the acknowledge fell
  p_ack_after_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(ctl_drive == '0));

  // R7: the acknowledge was already high before the pads were driven again
  p_drive_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_drive[0]) |-> $past(hold_ack_n));

  // R4: the pads float only when the engine was idle
  p_float_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_drive[0]) |-> !$past(eng_busy));

  // R9: the acknowledge moves only on a bus-clock edge
  p_ack_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_ack_n) |-> $past(bclk_en));

  // R9: the drive enables move only on a bus-clock edge
  p_drive_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_drive) |-> $past(bclk_en));

  // R3: the engine is stalled while the bus is released
  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_drive == '0) |-> !eng_grant);

endmodule

bind bus_hold_ctrl bus_hold_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CS_W   (CS_W)
) chk_i (.*);

// File: tb/bus_hold_ctrl_tb_top.sv
`timescale 1ns/100ps
module bus_hold_ctrl_tb_top;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int CS_W   = 3;
  localparam int NVEC   = 38;

  logic              clk;
  logic              rst_n;
  logic              bclk_en;
  logic              hold_req_n;
  logic              hold_ack_n;
  logic              eng_busy;
  logic              eng_grant;
  logic [ADDR_W-1:0] addr_drive;
  logic [DATA_W-1:0] data_drive;
  logic [CS_W:0]     ctl_drive;

  int checks;
  int errors;

  bus_hold_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_W(CS_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_en    (bclk_en),
    .hold_req_n (hold_req_n),
    .hold_ack_n (hold_ack_n),
    .eng_busy   (eng_busy),
    .eng_grant  (eng_grant),
    .addr_drive (addr_drive),
    .data_drive (data_drive),
    .ctl_drive  (ctl_drive)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // row: {req_n, busy, bclk_en, exp_ack_n, exp_drive, exp_grant, tag[3:0]}
  // inputs set before edge k; expectation is the state after edge k
  localparam logic [9:0] VEC [NVEC] = '{
    {3'b101, 3'b111, 4'd1 },  // 0  R1 idle
    {3'b000, 3'b111, 4'd3 },  // 1  R3 request low, not yet seen
    {3'b001, 3'b110, 4'd2 },  // 2  R2 second sync stage removes grant
    {3'b000, 3'b110, 4'd9 },  // 3  R9 no bus edge, nothing moves
    {3'b001, 3'b100, 4'd5 },  // 4  R5 float on bus edge
    {3'b000, 3'b100, 4'd5 },  // 5  R5
    {3'b001, 3'b000, 4'd6 },  // 6  R6 ack one bus clock later
    {3'b100, 3'b000, 4'd6 },  // 7  R6 release requested
    {3'b101, 3'b000, 4'd7 },  // 8  R7 still in sync pipe
    {3'b100, 3'b000, 4'd9 },  // 9  R9 seen, but no bus edge
    {3'b101, 3'b100, 4'd7 },  // 10 R7 ack high first
    {3'b100, 3'b100, 4'd7 },  // 11 R7
    {3'b101, 3'b111, 4'd7 },  // 12 R7 pads driven one bus clock later
    {3'b100, 3'b111, 4'd3 },  // 13 R3 grant back
    {3'b011, 3'b111, 4'd3 },  // 14 R3 busy engine, new request
    {3'b010, 3'b110, 4'd2 },  // 15 R2
    {3'b011, 3'b110, 4'd4 },  // 16 R4 draining
    {3'b010, 3'b110, 4'd4 },  // 17 R4
    {3'b011, 3'b110, 4'd4 },  // 18 R4 still busy on bus edge
    {3'b000, 3'b110, 4'd9 },  // 19 R9 idle, no bus edge
    {3'b001, 3'b100, 4'd4 },  // 20 R4 float once idle
    {3'b000, 3'b100, 4'd5 },  // 21 R5
    {3'b001, 3'b000, 4'd6 },  // 22 R6
    {3'b100, 3'b000, 4'd6 },  // 23 R6
    {3'b101, 3'b000, 4'd7 },  // 24 R7
    {3'b100, 3'b000, 4'd9 },  // 25 R9
    {3'b101, 3'b100, 4'd7 },  // 26 R7
    {3'b000, 3'b100, 4'd10},  // 27 R10 request during release
    {3'b001, 3'b110, 4'd10},  // 28 R10 pads first, grant stays off
    {3'b000, 3'b110, 4'd10},  // 29 R10
    {3'b001, 3'b100, 4'd10},  // 30 R10 normal entry
    {3'b100, 3'b100, 4'd8 },  // 31 R8 withdrawn before ack
    {3'b101, 3'b000, 4'd8 },  // 32 R8 grant still completed
    {3'b100, 3'b000, 4'd8 },  // 33 R8
    {3'b101, 3'b100, 4'd8 },  // 34 R8 release
    {3'b100, 3'b100, 4'd8 },  // 35 R8
    {3'b101, 3'b111, 4'd8 },  // 36 R8 bus back
    {3'b100, 3'b111, 4'd3 }   // 37 R3
  };

  task automatic check_out(input string tag, input logic e_ack, input logic e_drv,
                           input logic e_gnt);
    logic ok;
    checks++;
    ok = (hold_ack_n === e_ack) && (eng_grant === e_gnt) &&
         (addr_drive === {ADDR_W{e_drv}}) && (data_drive === {DATA_W{e_drv}}) &&
         (ctl_drive === {(CS_W+1){e_drv}});
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t ack=%b drv=%h/%h/%h gnt=%b expected ack=%b drv=%b gnt=%b",
               tag, $time, hold_ack_n, addr_drive, data_drive, ctl_drive, eng_grant,
               e_ack, e_drv, e_gnt);
    end
  endtask

  // apply inputs at a falling edge, return at the next falling edge
  task automatic cyc(input logic r, input logic b, input logic c);
    hold_req_n = r;
    eng_busy   = b;
    bclk_en    = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    hold_req_n = 1'b1;
    eng_busy = 1'b0;
    bclk_en = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 1'b1, 1'b1, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'(i % 2));
    check_out("R1 after reset", 1'b1, 1'b1, 1'b1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][9], VEC[i][8], VEC[i][7]);
      check_out($sformatf("row %0d R%0d", i, VEC[i][3:0]),
                VEC[i][6], VEC[i][5], VEC[i][4]);
    end

    // R9: long request with no bus edge moves nothing but the grant
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b0);
    check_out("R9 no bus edge", 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    check_out("R9 first bus edge floats", 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    check_out("R6 held", 1'b0, 1'b0, 1'b0);

    // R1: reset in the middle of a hold restores the idle outputs at once
    #1 rst_n = 1'b0;
    #0.5;
    check_out("R1 async reset mid-hold", 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    hold_req_n = 1'b1;
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'(i % 2));
    check_out("R1 idle after reset", 1'b1, 1'b1, 1'b1);

    // R2: a fall reaches the grant only after the second stage
    cyc(1'b0, 1'b0, 1'b0);
    check_out("R2 one edge", 1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    check_out("R2 two edges", 1'b1, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule